// File: doc/BRIEF.md
# Memory-Side Snooping Coherence Controller

This block is the memory side of an MSI snooping coherence scheme. It watches every ordered bus request (read-shared, read-for-ownership, owner writeback) for a small set of memory blocks. For each block it decides whether memory answers the request with data, and when memory's copy must be refreshed with data returned by the owning cache. Memory does not tell Invalid and Shared apart. Each block sits in one of three states: a merged "no owner" state, an "owned" state in which exactly one cache holds the only writable copy, and a transient "waiting for owner data" state.

When memory must answer, the block produces a one-cycle response carrying the requester's identifier and the stored word. When a cache that gave up or downgraded its ownership returns its data, the block writes the word into its small behavioural memory in the same cycle and drops back to the "no owner" state. While a block waits for that data, any bus request to it is held off with a stall signal, and the requester keeps the request on the bus. Unexpected owner data, and requests that make no sense in the current state, raise a one-cycle protocol error and change nothing. Bus arbitration is done elsewhere.

Top module: `memSnoopCtl`

## Requirements
- R1: After reset every block is in the no-owner state, `ownedVec` is all zero, `respValid` and `protoErr` are low, and memory word i holds the value i.
- R2: An accepted read-shared request (`busOp` 0) to a block with no owner gives, one cycle later, `respValid` high with `respReqId` equal to the requester and `respData` equal to the stored word. The block stays without an owner.
- R3: An accepted read-for-ownership request (`busOp` 1) to a block with no owner gives the same data response as R2, and from the next cycle `ownedVec` shows the block as owned.
- R4: A read-shared request to an owned block gets no memory response. It clears the block's `ownedVec` bit and puts the block into the waiting state.
- R5: A read-for-ownership request to an owned block gets no memory response, and the block stays owned.
- R6: An owner writeback request (`busOp` 2) to an owned block gets no memory response. It clears the owned bit and puts the block into the waiting state.
- R7: While a block waits, `busStall` is high in the same cycle as any bus request to it. The request produces no response and does not change the block's state.
- R8: Owner data (`ownerValid`) for a waiting block raises `memWrEn` in that cycle and stores `ownerData`. The block returns to no-owner, so a later read-shared request is accepted and returns the new word.
- R9: Owner data for a block that is not waiting leaves `memWrEn` low and memory unchanged, and raises `protoErr` one cycle later.
- R10: An owner writeback to a block with no owner, or the reserved `busOp` 3, raises `protoErr` one cycle later. It produces no response and changes no state.
- R11: Owner data for one block and a bus request to a different block in the same cycle both take full effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busValid | input | 1 | A bus request is present |
| busOp | input | 2 | 0 read-shared, 1 read-for-ownership, 2 owner writeback, 3 reserved |
| busAddr | input | ADDR_W | Block index of the request |
| busReqId | input | REQ_W | Identifier of the requesting cache |
| busStall | output | 1 | Request held off; target block waits for owner data |
| ownerValid | input | 1 | Owner cache is returning block data |
| ownerAddr | input | ADDR_W | Block index of the returned data |
| ownerData | input | DATA_W | Returned data word |
| respValid | output | 1 | Memory response strobe |
| respReqId | output | REQ_W | Requester the response is for |
| respData | output | DATA_W | Data supplied by memory |
| memWrEn | output | 1 | Memory write strobe in this cycle |
| protoErr | output | 1 | Protocol error seen in the previous cycle |
| ownedVec | output | NUM_BLOCKS | Per-block flag: a cache holds the block writable |

## Verification
The bench builds the block with four blocks, 16-bit data and a 2-bit requester identifier. With four blocks, every block's reset word can be read back. It also allows owner data for one block and a request to another in the same cycle. Two caches are modelled beside the controller, so ownership moves between them. After every transaction the bench checks that at most one cache can write a block and that `ownedVec` agrees with that model.

// File: rtl/memSnoopPkg.sv
package memSnoopPkg;

  // Bus request codes; the order is part of the block's interface.
  typedef enum logic [1:0] {
    OP_READ_SHARED = 2'd0,
    OP_READ_OWN    = 2'd1,
    OP_WRITEBACK   = 2'd2,
    OP_RESERVED    = 2'd3
  } busOpE;

  // Memory-side view of one block.
  typedef enum logic [1:0] {
    BLK_NO_OWNER = 2'd0,
    BLK_OWNED    = 2'd1,
    BLK_WAIT     = 2'd2
  } blkStateE;

  // Strobes from control to datapath.
  typedef struct packed {
    logic sendResp;
    logic memWr;
    logic protoErr;
  } ctlStrobeS;

endpackage

// File: rtl/memSnoopCtrl.sv
module memSnoopCtrl
  import memSnoopPkg::*;
#(
  parameter int NUM_BLOCKS = 4,
  parameter int ADDR_W     = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  busValid,
  input  logic [1:0]            busOp,
  input  logic [ADDR_W-1:0]     busAddr,
  input  logic                  ownerValid,
  input  logic [ADDR_W-1:0]     ownerAddr,
  output logic                  busStall,
  output logic [NUM_BLOCKS-1:0] ownedVec,
  output ctlStrobeS             strobe
);

  logic [NUM_BLOCKS-1:0] isWait;
  logic [NUM_BLOCKS-1:0] respB;
  logic [NUM_BLOCKS-1:0] wrB;
  logic [NUM_BLOCKS-1:0] errB;

  logic  accept;
  logic  ownerErr;
  busOpE opIn;

  assign opIn     = busOpE'(busOp);
  assign busStall = busValid && isWait[busAddr];
  assign accept   = busValid && !isWait[busAddr];
  assign ownerErr = ownerValid && !isWait[ownerAddr];

  for (genvar b = 0; b < NUM_BLOCKS; b++) begin : g_blk
    blkStateE stateQ, stateD;
    logic     busHit, ownHit;

    assign busHit = accept && (busAddr == ADDR_W'(b));
    assign ownHit = ownerValid && (ownerAddr == ADDR_W'(b));

    always_comb begin
      stateD   = stateQ;
      respB[b] = 1'b0;
      wrB[b]   = 1'b0;
      errB[b]  = 1'b0;
      unique case (stateQ)
        BLK_NO_OWNER: if (busHit) begin
          unique case (opIn)
            OP_READ_SHARED: respB[b] = 1'b1;
            OP_READ_OWN: begin
              respB[b] = 1'b1;
              stateD   = BLK_OWNED;
            end
            default: errB[b] = 1'b1;
          endcase
        end
        BLK_OWNED: if (busHit) begin
          unique case (opIn)
            OP_READ_SHARED: stateD = BLK_WAIT;
            OP_READ_OWN:    stateD = BLK_OWNED;
            OP_WRITEBACK:   stateD = BLK_WAIT;
            default:        errB[b] = 1'b1;
          endcase
        end
        BLK_WAIT: if (ownHit) begin
          wrB[b] = 1'b1;
          stateD = BLK_NO_OWNER;
        end
        default: stateD = BLK_NO_OWNER;
      endcase
    end

    always_ff @(posedge clk) begin
      if (!rstN) stateQ <= BLK_NO_OWNER;
      else       stateQ <= stateD;
    end

    assign isWait[b]   = (stateQ == BLK_WAIT);
    assign ownedVec[b] = (stateQ == BLK_OWNED);
  end

  assign strobe.sendResp = |respB;
  assign strobe.memWr    = |wrB;
  assign strobe.protoErr = (|errB) || ownerErr;

endmodule

// File: rtl/memSnoopData.sv
module memSnoopData
  import memSnoopPkg::*;
#(
  parameter int NUM_BLOCKS = 4,
  parameter int ADDR_W     = 2,
  parameter int DATA_W     = 32,
  parameter int REQ_W      = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobeS         strobe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [REQ_W-1:0]  busReqId,
  input  logic [ADDR_W-1:0] ownerAddr,
  input  logic [DATA_W-1:0] ownerData,
  output logic              respValid,
  output logic [REQ_W-1:0]  respReqId,
  output logic [DATA_W-1:0] respData,
  output logic              memWrEn,
  output logic              protoErr
);

  logic [DATA_W-1:0] memWord [NUM_BLOCKS];

  for (genvar w = 0; w < NUM_BLOCKS; w++) begin : g_word
    always_ff @(posedge clk) begin
      if (!rstN)
        memWord[w] <= DATA_W'(w);
      else if (strobe.memWr && (ownerAddr == ADDR_W'(w)))
        memWord[w] <= ownerData;
    end
  end

  assign memWrEn = strobe.memWr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      respValid <= 1'b0;
      respReqId <= '0;
      respData  <= '0;
      protoErr  <= 1'b0;
    end else begin
      respValid <= strobe.sendResp;
      protoErr  <= strobe.protoErr;
      if (strobe.sendResp) begin
        respReqId <= busReqId;
        respData  <= memWord[busAddr];
      end
    end
  end

endmodule

// File: rtl/memSnoopCtl.sv
module memSnoopCtl
  import memSnoopPkg::*;
#(
  parameter int NUM_BLOCKS = 4,
  parameter int DATA_W     = 32,
  parameter int REQ_W      = 2,
  parameter int ADDR_W     = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  busValid,
  input  logic [1:0]            busOp,
  input  logic [ADDR_W-1:0]     busAddr,
  input  logic [REQ_W-1:0]      busReqId,
  output logic                  busStall,
  input  logic                  ownerValid,
  input  logic [ADDR_W-1:0]     ownerAddr,
  input  logic [DATA_W-1:0]     ownerData,
  output logic                  respValid,
  output logic [REQ_W-1:0]      respReqId,
  output logic [DATA_W-1:0]     respData,
  output logic                  memWrEn,
  output logic                  protoErr,
  output logic [NUM_BLOCKS-1:0] ownedVec
);

  ctlStrobeS strobe;

  memSnoopCtrl #(.NUM_BLOCKS(NUM_BLOCKS), .ADDR_W(ADDR_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .busValid  (busValid),
    .busOp     (busOp),
    .busAddr   (busAddr),
    .ownerValid(ownerValid),
    .ownerAddr (ownerAddr),
    .busStall  (busStall),
    .ownedVec  (ownedVec),
    .strobe    (strobe)
  );

  memSnoopData #(
    .NUM_BLOCKS(NUM_BLOCKS), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .REQ_W(REQ_W)
  ) u_data (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .busAddr  (busAddr),
    .busReqId (busReqId),
    .ownerAddr(ownerAddr),
    .ownerData(ownerData),
    .respValid(respValid),
    .respReqId(respReqId),
    .respData (respData),
    .memWrEn  (memWrEn),
    .protoErr (protoErr)
  );

endmodule

// File: rtl/memSnoopCtlChk.sv
module memSnoopCtlChk #(
  parameter int NUM_BLOCKS = 4,
  parameter int ADDR_W     = 2
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  busValid,
  input logic [1:0]            busOp,
  input logic [ADDR_W-1:0]     busAddr,
  input logic                  busStall,
  input logic                  ownerValid,
  input logic                  respValid,
  input logic                  memWrEn,
  input logic                  protoErr,
  input logic [NUM_BLOCKS-1:0] ownedVec
);

  // R2: a response only follows an accepted request
  p_resp_accept_r2: assert property (@(posedge clk) disable iff (!rstN)
    respValid |-> $past(busValid && !busStall));

  // R3: an accepted read-for-ownership leaves the block owned
  p_getm_owned_r3: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && !busStall && busOp == 2'd1) |=> ownedVec[$past(busAddr)]);

  // R4: read-shared to an owned block: no response, ownership dropped
  p_gets_owned_r4: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && !busStall && busOp == 2'd0 && ownedVec[busAddr])
      |=> (!respValid && !ownedVec[$past(busAddr)]));

  // R6: owner writeback never gets a memory response
  p_putm_quiet_r6: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && !busStall && busOp == 2'd2) |=> !respValid);

  // R7: a stalled request produces no response
  p_stall_quiet_r7: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && busStall) |=> !respValid);

  // R8: memory is written only while owner data is present
  p_wr_owner_r8: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn |-> ownerValid);

  // R9: unused owner data raises an error next cycle
  p_owner_err_r9: assert property (@(posedge clk) disable iff (!rstN)
    (ownerValid && !memWrEn) |=> protoErr);

endmodule

bind memSnoopCtl memSnoopCtlChk #(.NUM_BLOCKS(NUM_BLOCKS), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .busValid  (busValid),
  .busOp     (busOp),
  .busAddr   (busAddr),
  .busStall  (busStall),
  .ownerValid(ownerValid),
  .respValid (respValid),
  .memWrEn   (memWrEn),
  .protoErr  (protoErr),
  .ownedVec  (ownedVec)
);

// File: tb/memSnoopCtl_tb.sv
module memSnoopCtl_tb;

  localparam int NB = 4;
  localparam int DW = 16;
  localparam int RW = 2;
  localparam int AW = 2;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          busValid = 1'b0;
  logic [1:0]    busOp = '0;
  logic [AW-1:0] busAddr = '0;
  logic [RW-1:0] busReqId = '0;
  logic          busStall;
  logic          ownerValid = 1'b0;
  logic [AW-1:0] ownerAddr = '0;
  logic [DW-1:0] ownerData = '0;
  logic          respValid;
  logic [RW-1:0] respReqId;
  logic [DW-1:0] respData;
  logic          memWrEn;
  logic          protoErr;
  logic [NB-1:0] ownedVec;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // Cache model: 0 invalid, 1 shared, 2 modified; two caches
  int cst [2][NB];

  always #2.5 clk = ~clk;

  memSnoopCtl #(.NUM_BLOCKS(NB), .DATA_W(DW), .REQ_W(RW)) u_dut (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busOp(busOp),
    .busAddr(busAddr), .busReqId(busReqId), .busStall(busStall),
    .ownerValid(ownerValid), .ownerAddr(ownerAddr), .ownerData(ownerData),
    .respValid(respValid), .respReqId(respReqId), .respData(respData),
    .memWrEn(memWrEn), .protoErr(protoErr), .ownedVec(ownedVec)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  // Drive one bus request; report same-cycle stall; return after the edge
  task automatic issue(input int op, input int a, input int id, output bit stall);
    busValid = 1'b1; busOp = 2'(op); busAddr = AW'(a); busReqId = RW'(id);
    #1 stall = busStall;
    tick();
    busValid = 1'b0;
  endtask

  task automatic ownerWb(input int a, input int d, output bit wr);
    ownerValid = 1'b1; ownerAddr = AW'(a); ownerData = DW'(d);
    #1 wr = memWrEn;
    tick();
    ownerValid = 1'b0;
  endtask

  task automatic modelGet(input int c, input int a, input bit own);
    if (own) begin
      cst[1-c][a] = 0;
      cst[c][a] = 2;
    end else begin
      if (cst[1-c][a] == 2) cst[1-c][a] = 1;
      cst[c][a] = 1;
    end
  endtask

  task automatic swmrCheck(input string tag);
    for (int a = 0; a < NB; a++) begin
      bit anyM = (cst[0][a] == 2) || (cst[1][a] == 2);
      bit bad = (cst[0][a] == 2 && cst[1][a] != 0) || (cst[1][a] == 2 && cst[0][a] != 0);
      chk(!bad, {tag, " single writer"}, a, 0);
      chk(ownedVec[a] == anyM, {tag, " ownedVec"}, int'(ownedVec[a]), int'(anyM));
    end
  endtask

  // R1 and R2: reset state and reads of every reset word
  task automatic testReset();
    bit s;
    chk(ownedVec == '0, "R1 ownedVec", int'(ownedVec), 0);
    chk(!respValid, "R1 respValid", int'(respValid), 0);
    chk(!protoErr, "R1 protoErr", int'(protoErr), 0);
    for (int a = 0; a < NB; a++) begin
      issue(0, a, a % 2, s);
      chk(!s, "R2 no stall", int'(s), 0);
      chk(respValid && respReqId == RW'(a % 2), "R2 resp id", int'(respReqId), a % 2);
      chk(respData == DW'(a), "R1 reset word", int'(respData), a);
      modelGet(a % 2, a, 1'b0);
    end
    swmrCheck("R2");
  endtask

  task automatic testOwnership();
    bit s, w;
    issue(1, 1, 0, s);
    chk(respValid && respData == 16'd1, "R3 data", int'(respData), 1);
    modelGet(0, 1, 1'b1);
    swmrCheck("R3");
    issue(1, 1, 1, s);
    chk(!respValid, "R5 no resp", int'(respValid), 0);
    modelGet(1, 1, 1'b1);
    swmrCheck("R5");
    issue(0, 1, 0, s);
    chk(!respValid, "R4 no resp", int'(respValid), 0);
    modelGet(0, 1, 1'b0);
    swmrCheck("R4");
    issue(0, 1, 1, s);
    chk(s, "R7 stall", int'(s), 1);
    chk(!respValid, "R7 no resp", int'(respValid), 0);
    // R11: owner data to block 1 with read of block 2 in one cycle
    ownerValid = 1'b1; ownerAddr = 2'd1; ownerData = 16'hBEEF;
    busValid = 1'b1; busOp = 2'd0; busAddr = 2'd2; busReqId = 2'd0;
    #1 w = memWrEn; s = busStall;
    tick();
    ownerValid = 1'b0; busValid = 1'b0;
    chk(w, "R8 memWrEn", int'(w), 1);
    chk(!s && respValid && respData == 16'd2, "R11 parallel read", int'(respData), 2);
    modelGet(0, 2, 1'b0);
    issue(0, 1, 1, s);
    chk(!s && respValid && respData == 16'hBEEF, "R8 new word", int'(respData), 'hBEEF);
    modelGet(1, 1, 1'b0);
    swmrCheck("R8");
  endtask

  task automatic testErrors();
    bit s, w;
    issue(2, 1, 0, s);
    chk(protoErr && !respValid, "R10 writeback no owner", int'(protoErr), 1);
    swmrCheck("R10");
    issue(3, 2, 0, s);
    chk(protoErr && !respValid, "R10 reserved op", int'(protoErr), 1);
    tick();
    chk(!protoErr, "R10 error clears", int'(protoErr), 0);
    ownerWb(3, 'h5A5A, w);
    chk(!w, "R9 no write", int'(w), 0);
    chk(protoErr, "R9 protoErr", int'(protoErr), 1);
    issue(0, 3, 1, s);
    chk(respData == 16'd3, "R9 word kept", int'(respData), 3);
  endtask

  task automatic testWriteback();
    bit s, w;
    issue(1, 0, 1, s);
    chk(respValid && respData == 16'd0 && respReqId == 2'd1, "R3 block0", int'(respData), 0);
    modelGet(1, 0, 1'b1);
    swmrCheck("R3");
    issue(2, 0, 1, s);
    chk(!respValid, "R6 no resp", int'(respValid), 0);
    cst[1][0] = 0;
    swmrCheck("R6");
    issue(1, 0, 0, s);
    chk(s && !respValid, "R7 stall after writeback", int'(s), 1);
    chk(ownedVec[0] == 1'b0, "R7 state kept", int'(ownedVec[0]), 0);
    ownerWb(0, 'h1234, w);
    chk(w && !protoErr, "R8 writeback stored", int'(w), 1);
    issue(0, 0, 0, s);
    chk(!s && respData == 16'h1234, "R8 read back", int'(respData), 'h1234);
    modelGet(0, 0, 1'b0);
    swmrCheck("R8");
  endtask

  initial begin
    for (int c = 0; c < 2; c++)
      for (int a = 0; a < NB; a++) cst[c][a] = 0;
    repeat (3) tick();
    rstN = 1'b1;
    tick();
    testReset();
    testOwnership();
    testErrors();
    testWriteback();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=0 expected=1");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule